// File: doc/BRIEF.md
# Cascadable Four-Channel Serial Switch Latch

This block holds the on/off requests for four low-side switches. A host loads them over a three-wire serial port: a serial clock, a data line and a latch strobe. Each serial clock edge moves one bit into a four-bit holding register. The bit that falls off the far end of that register leaves on a serial data output. That output can feed the data input of the next block, so several blocks share one serial port. A latch strobe copies the holding register into an output register, and all four channels change together.

The output register is combined with an active-low enable and a per-channel fault-disable input. Together they form the four switch-on requests. The enable and the fault disables act only on the outputs. They do not change the shifting or the latched data, so when a disable is removed the latched state shows again.

The serial clock, data and strobe come from outside the system clock domain. They are synchronised and edge-detected on the system clock. The host must hold each serial level for longer than the synchroniser delay.

Top module: `serial_switch_latch`

## Requirements
- R1: On each rising edge of `sclk_i`, the holding register shifts up by one place and takes the synchronised `sdi_i` into bit 0 (channel 0).
- R2: `sdo_o` is bit 3 of the holding register. A bit that enters `sdi_i` appears on `sdo_o` after four serial clock edges, so a second block fed from `sdo_o` receives the first four bits of an eight-bit stream.
- R3: On a rising edge of `latch_i`, the holding register is copied into the output register. Between strobes the output register keeps its value while bits are shifting.
- R4: `sw_on_o[i]` is 1 only when latched bit i is 1, `en_ni` is 0 and `fault_dis_i[i]` is 0.
- R5: `en_ni` has no effect on shifting or latching. Data shifted and latched while `en_ni` is 1 appears on the outputs once `en_ni` goes to 0.
- R6: A high level on `clr_i` at a clock edge clears both the holding register and the output register.
- R7: A low level on `rst_ni` clears both registers without waiting for a clock edge. After reset, `sw_on_o` and `sdo_o` are 0.
- R8: When a `latch_i` rising edge and an `sclk_i` rising edge reach the block in the same cycle, the output register takes the holding value from before that shift.
- R9: A set `fault_dis_i[i]` forces channel i off but leaves latched bit i unchanged. Clearing it restores the channel with no new strobe.
- R10: Only rising edges shift. Holding `sclk_i` high for many system clocks causes exactly one shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up reset) |
| clr_i | input | 1 | Synchronous active-high clear of both registers |
| sclk_i | input | 1 | Serial clock, sampled and edge-detected |
| sdi_i | input | 1 | Serial data input |
| latch_i | input | 1 | Latch strobe, rising edge copies the holding register |
| en_ni | input | 1 | Active-low output enable |
| fault_dis_i | input | N_CH | Per-channel forced-off input |
| sdo_o | output | 1 | Serial data output to the next block in a chain |
| sw_on_o | output | N_CH | Switch-on requests |

## Verification
The hardest case to reach from the ports is a latch edge that lands in the same system cycle as a shift edge. The bench drives `latch_i` and `sclk_i` high at the same instant, so both pass through identical synchronisers and are detected in one cycle. It then latches again by itself, which proves that the shift did happen and that the first strobe saw the value from before it. Two blocks are cascaded so that the serial output path is also checked through a real downstream register.

// File: rtl/sw_latch_pkg.sv
package sw_latch_pkg;
  localparam int unsigned DEF_N_CH        = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/sync_delay.sv
module sync_delay #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic lvl;
  logic prev_q;

  sync_delay #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d_i),
    .q_o   (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  assign rise_o = lvl & ~prev_q;
endmodule

// File: rtl/hold_shift.sv
module hold_shift #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         sdi_i,
  input  logic         latch_i,
  output logic [N-1:0] hold_o,
  output logic [N-1:0] lat_o
);
  logic [N-1:0] hold_q;
  logic [N-1:0] lat_q;

  // Nonblocking update: a coincident strobe takes the pre-shift value.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      lat_q  <= '0;
    end else if (clr_i) begin
      hold_q <= '0;
      lat_q  <= '0;
    end else begin
      if (shift_i) hold_q <= {hold_q[N-2:0], sdi_i};
      if (latch_i) lat_q  <= hold_q;
    end
  end

  assign hold_o = hold_q;
  assign lat_o  = lat_q;
endmodule

// File: rtl/out_gate.sv
module out_gate #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] lat_i,
  input  logic         en_ni,
  input  logic [N-1:0] fault_dis_i,
  output logic [N-1:0] sw_on_o
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_ch
      assign sw_on_o[g] = lat_i[g] & ~en_ni & ~fault_dis_i[g];
    end
  endgenerate
endmodule

// File: rtl/serial_switch_latch.sv
module serial_switch_latch
  import sw_latch_pkg::*;
#(
  parameter int unsigned N_CH        = DEF_N_CH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            sclk_i,
  input  logic            sdi_i,
  input  logic            latch_i,
  input  logic            en_ni,
  input  logic [N_CH-1:0] fault_dis_i,
  output logic            sdo_o,
  output logic [N_CH-1:0] sw_on_o
);
  logic            sclk_rise;
  logic            latch_rise;
  logic            sdi_s;
  logic [N_CH-1:0] hold_q;
  logic [N_CH-1:0] lat_q;

  edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sclk_i),
    .rise_o(sclk_rise)
  );

  edge_sync #(.STAGES(SYNC_STAGES)) u_latch_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (latch_i),
    .rise_o(latch_rise)
  );

  // Data is delayed as much as the clock so that sampling lines up.
  sync_delay #(.STAGES(SYNC_STAGES)) u_sdi_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sdi_i),
    .q_o   (sdi_s)
  );

  hold_shift #(.N(N_CH)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .shift_i(sclk_rise),
    .sdi_i  (sdi_s),
    .latch_i(latch_rise),
    .hold_o (hold_q),
    .lat_o  (lat_q)
  );

  out_gate #(.N(N_CH)) u_gate (
    .lat_i      (lat_q),
    .en_ni      (en_ni),
    .fault_dis_i(fault_dis_i),
    .sw_on_o    (sw_on_o)
  );

  assign sdo_o = hold_q[N_CH-1];
endmodule

// File: rtl/sw_latch_checker.sv
module sw_latch_checker #(
  parameter int unsigned N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_i,
  input logic         en_ni,
  input logic [N-1:0] fault_dis_i,
  input logic [N-1:0] sw_on_o,
  input logic         sdo_o,
  input logic [N-1:0] hold_q,
  input logic [N-1:0] lat_q,
  input logic         sclk_rise,
  input logic         latch_rise
);
  // R1
  a_r1_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && !clr_i) |=> (hold_q[N-1:1] == $past(hold_q[N-2:0])));

  // R2
  a_r2_sdo_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && !clr_i) |=> (sdo_o == $past(hold_q[N-2])));

  // R3
  a_r3_latch_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_rise && !clr_i) |=> (lat_q == $past(hold_q)));

  a_r3_lat_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_rise && !clr_i) |=> $stable(lat_q));

  // R4
  a_r4_enable_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |-> (sw_on_o == '0));

  a_r4_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sw_on_o & ~lat_q) == '0));

  // R9
  a_r9_fault_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sw_on_o & fault_dis_i) == '0));

  // R6
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((hold_q == '0) && (lat_q == '0)));

  // R10
  a_r10_no_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_rise && !clr_i) |=> $stable(hold_q));
endmodule

bind serial_switch_latch sw_latch_checker #(.N(N_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .en_ni      (en_ni),
  .fault_dis_i(fault_dis_i),
  .sw_on_o    (sw_on_o),
  .sdo_o      (sdo_o),
  .hold_q     (hold_q),
  .lat_q      (lat_q),
  .sclk_rise  (sclk_rise),
  .latch_rise (latch_rise)
);

// File: tb/serial_switch_latch_test.sv
`timescale 1ns/1ps
module serial_switch_latch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic       latch = 1'b0;
  logic       en_n = 1'b1;
  logic [3:0] fault_a = '0;
  logic [3:0] fault_b = '0;
  logic       sdo_a, sdo_b;
  logic [3:0] sw_a, sw_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    string      req;
    logic [3:0] a;
    logic [3:0] b;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  serial_switch_latch uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .sclk_i(sclk), .sdi_i(sdi),
    .latch_i(latch), .en_ni(en_n), .fault_dis_i(fault_a),
    .sdo_o(sdo_a), .sw_on_o(sw_a)
  );

  serial_switch_latch uut2 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .sclk_i(sclk), .sdi_i(sdo_a),
    .latch_i(latch), .en_ni(en_n), .fault_dis_i(fault_b),
    .sdo_o(sdo_b), .sw_on_o(sw_b)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares both blocks' outputs at the next falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.req, " first"},  sw_a, e.a);
        chk({e.req, " second"}, sw_b, e.b);
      end
    end
  end

  task automatic expect_out(input string req, input logic [3:0] a, input logic [3:0] b);
    exp_t e;
    e.req = req; e.a = a; e.b = b;
    sb_q.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input int high_cycles);
    @(negedge clk);
    sdi  = v;
    sclk = 1'b1;
    repeat (high_cycles) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] w);
    for (int i = 7; i >= 0; i--) send_bit(w[i], 4);
  endtask

  task automatic pulse_latch();
    @(negedge clk);
    latch = 1'b1;
    repeat (4) @(negedge clk);
    latch = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7 reset sw_a", sw_a, 4'h0);
    chk("R7 reset sdo", {3'b0, sdo_a}, 4'h0);
    rst_n = 1'b1;
    en_n  = 1'b0;
    repeat (2) @(negedge clk);

    // R1, R2 cascade, R3 outputs held until strobe
    send_word(8'hA5);
    expect_out("R3 before strobe", 4'h0, 4'h0);
    pulse_latch();
    expect_out("R1 R2 cascade", 4'h5, 4'hA);

    // R2: serial out is bit 3 of the holding register
    chk("R2 sdo msb", {3'b0, sdo_a}, 4'h0);
    send_bit(1'b1, 4);   // hold_a 0101 -> 1011
    chk("R2 sdo after shift", {3'b0, sdo_a}, 4'h1);
    expect_out("R3 hold during shift", 4'h5, 4'hA);

    // R5 and R4: enable gates outputs only
    en_n = 1'b1;
    send_word(8'h3C);
    pulse_latch();
    expect_out("R4 disabled", 4'h0, 4'h0);
    en_n = 1'b0;
    expect_out("R5 shift while disabled", 4'hC, 4'h3);

    // R9: fault disable masks without losing the latched bit
    fault_a = 4'b0100;
    fault_b = 4'b0001;
    expect_out("R9 fault masked", 4'h8, 4'h2);
    fault_a = 4'b0000;
    fault_b = 4'b0000;
    expect_out("R9 fault released", 4'hC, 4'h3);

    // R8: coincident strobe and shift latch the pre-shift value
    send_word(8'hF0);
    @(negedge clk);
    sdi = 1'b1; sclk = 1'b1; latch = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0; latch = 1'b0;
    repeat (4) @(negedge clk);
    expect_out("R8 pre-shift latched", 4'h0, 4'hF);
    pulse_latch();
    expect_out("R8 shift did occur", 4'h1, 4'hE);

    // R6: clear both registers
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    expect_out("R6 clear outputs", 4'h0, 4'h0);
    pulse_latch();
    expect_out("R6 holding cleared", 4'h0, 4'h0);

    // R10: a long high level shifts once
    send_bit(1'b1, 20);
    pulse_latch();
    expect_out("R10 single shift", 4'h1, 4'h0);

    // R7: asynchronous reset mid-operation
    send_word(8'hFF);
    pulse_latch();
    expect_out("R7 loaded", 4'hF, 4'hF);
    #1 rst_n = 1'b0;
    #1;
    chk("R7 async first", sw_a, 4'h0);
    chk("R7 async second", sw_b, 4'h0);
    chk("R7 async sdo", {3'b0, sdo_b}, 4'h0);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule